// File: doc/BRIEF.md
# Carry-Save Transposed FIR Filter

This block is a fixed-coefficient FIR filter in transposed direct form. Every accepted input sample is multiplied at the same moment by all tap coefficients. Each constant multiplier is a shift-and-add network built from 3:2 carry-save adders, and its product stays as a sum word and a carry word. The partial sums that move from tap to tap are also kept as sum and carry word pairs. Carry propagation happens in one place only: a registered vector merging adder at the output, which turns the final redundant pair into a two's complement sample.

The input is a plain signed binary word with a valid strobe. The filter state moves forward only on cycles where the strobe is high, so idle cycles between samples are allowed. Coefficients, widths and the digit recoding used by the multipliers are elaboration parameters. The default build has the four taps 41, 55, 79 and 1 and produces a full-precision result with no rounding. All redundant arithmetic is done at the full output width, modulo 2^OW, so no carry-save word is ever sign-extended.

Top module: `cs_tfir`

## Requirements
- R1: An active-low asynchronous reset `rst_n` clears everything. While reset is asserted, and on the first cycle after it is released, `out_valid` is 0 and `out_sample` is 0. Samples from before the reset add nothing to any later output.
- R2: For the m-th accepted sample x[m], the output is y[m] = 41*x[m] + 55*x[m-1] + 79*x[m-2] + 1*x[m-3]. Here x is an 8-bit two's complement number, y is an exact 16-bit two's complement number, and samples before the first accepted one count as zero.
- R3: A sample accepted at rising edge t (with `in_valid` high) produces `out_valid` high, with its result on `out_sample`, during the cycle that follows edge t+1. `out_valid` is low in every other cycle.
- R4: A cycle with `in_valid` low is ignored: the tap history does not advance, so later outputs are the same as if that cycle had not happened.
- R5: `out_sample` keeps its value in every cycle where `out_valid` is low.
- R6: Full-scale inputs do not wrap. A run of four or more samples of 127 gives 22352, and a run of four or more samples of -128 gives -22528.
- R7: Samples may arrive on every clock with no gap, one result per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | High when `in_sample` carries a new sample |
| in_sample | input | IW (8) | Signed input sample, two's complement |
| out_valid | output | 1 | High for one cycle per filtered result |
| out_sample | output | OW (16) | Signed filter output, two's complement |

## Verification
The bench sends impulses of both signs, including the most negative input code, to check that each product's two's complement term and its constant correction land in the right bit positions. A wrong negative-digit correction would show up as an offset of a few LSBs on one tap only. Runs of full-scale positive and negative samples target the MSB of the carry word: a merge or a carry shift that mishandles the top bit would wrap to the wrong sign. Random samples with random idle gaps, back-to-back bursts and a reset in the middle of a stream are aimed at a state chain that advances on idle cycles, an output register that changes without valid, and history left over after a reset.

// File: rtl/cs_tfir_pkg.sv
package cs_tfir_pkg;

   // Digit recoding used to build each constant multiplier
   typedef enum logic {
      RECODE_BINARY = 1'b0,   // one term per set bit of the coefficient
      RECODE_CSD    = 1'b1    // canonic signed digits, fewer terms
   } recode_e;

   // Canonic signed-digit masks of a non-negative constant below 2^31.
   // Result is {negative digit mask, positive digit mask}.
   function automatic logic [63:0] csd_masks(input logic [31:0] value);
      logic [32:0] rem;
      logic [31:0] pos;
      logic [31:0] neg;
      rem = {1'b0, value};
      pos = '0;
      neg = '0;
      for (int i = 0; i < 32; i++) begin
         if (rem[0]) begin
            if (rem[1]) begin
               neg[i] = 1'b1;
               rem    = rem + 33'd1;
            end else begin
               pos[i] = 1'b1;
               rem    = rem - 33'd1;
            end
         end
         rem = rem >> 1;
      end
      return {neg, pos};
   endfunction

endpackage

// File: rtl/cs_csa3.sv
module cs_csa3 #(
   parameter int W = 16
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [W-1:0] d,
   output logic [W-1:0] s,
   output logic [W-1:0] c
);

   if (W < 2) begin : g_bad_w
      $error("cs_csa3: W must be at least 2");
   end

   // Full-adder row; the carry leaving the top bit is dropped (modulo 2^W)
   assign s = a ^ b ^ d;
   assign c = {(a[W-2:0] & b[W-2:0]) | (a[W-2:0] & d[W-2:0]) | (b[W-2:0] & d[W-2:0]), 1'b0};

endmodule

// File: rtl/cs_const_mult.sv
module cs_const_mult
   import cs_tfir_pkg::*;
#(
   parameter int            IW        = 8,
   parameter int            OW        = 16,
   parameter int            CW        = 8,
   parameter logic [CW-1:0] COEF_VAL  = '0,
   parameter recode_e       RECODE    = RECODE_CSD
) (
   input  logic signed [IW-1:0] x,
   output logic        [OW-1:0] p_s,
   output logic        [OW-1:0] p_c
);

   localparam logic [63:0] MASKS = (RECODE == RECODE_CSD) ? csd_masks(32'(COEF_VAL))
                                                          : {32'd0, 32'(COEF_VAL)};
   localparam logic [31:0] POS   = MASKS[31:0];
   localparam logic [31:0] NEG   = MASKS[63:32];
   localparam int          NNEG  = $countones(NEG);
   localparam int          STAGES = CW + 1;

   if (CW < 1 || CW > 31) begin : g_bad_cw
      $error("cs_const_mult: CW must be in 1..31");
   end

   logic signed [OW-1:0] xw;
   assign xw = x;   // sign extension of the binary input, done once

   logic [STAGES:0][OW-1:0] s_chain;
   logic [STAGES:0][OW-1:0] c_chain;

   assign s_chain[0] = '0;
   assign c_chain[0] = '0;

   // One carry-save stage per nonzero digit; zero digits pass straight through
   for (genvar j = 0; j < STAGES; j++) begin : g_digit
      if (POS[j] || NEG[j]) begin : g_term
         logic [OW-1:0] term;
         if (NEG[j]) begin : g_sub
            assign term = ~OW'(xw << j);   // the +1 is added once, below
         end else begin : g_add
            assign term = OW'(xw << j);
         end
         cs_csa3 #(.W(OW)) u_csa (
            .a (s_chain[j]),
            .b (c_chain[j]),
            .d (term),
            .s (s_chain[j+1]),
            .c (c_chain[j+1])
         );
      end else begin : g_skip
         assign s_chain[j+1] = s_chain[j];
         assign c_chain[j+1] = c_chain[j];
      end
   end

   // Collected two's complement corrections of all negative digits
   if (NNEG > 0) begin : g_corr
      cs_csa3 #(.W(OW)) u_corr (
         .a (s_chain[STAGES]),
         .b (c_chain[STAGES]),
         .d (OW'(NNEG)),
         .s (p_s),
         .c (p_c)
      );
   end else begin : g_nocorr
      assign p_s = s_chain[STAGES];
      assign p_c = c_chain[STAGES];
   end

endmodule

// File: rtl/cs_tap.sv
module cs_tap #(
   parameter int OW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [OW-1:0] p_s,
   input  logic [OW-1:0] p_c,
   input  logic [OW-1:0] z_s,
   input  logic [OW-1:0] z_c,
   output logic [OW-1:0] q_s,
   output logic [OW-1:0] q_c
);

   logic [OW-1:0] t_s, t_c;
   logic [OW-1:0] n_s, n_c;

   // 4:2 reduction: two cascaded 3:2 rows
   cs_csa3 #(.W(OW)) u_row0 (
      .a (p_s), .b (p_c), .d (z_s),
      .s (t_s), .c (t_c)
   );

   cs_csa3 #(.W(OW)) u_row1 (
      .a (t_s), .b (t_c), .d (z_c),
      .s (n_s), .c (n_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_s <= '0;
         q_c <= '0;
      end else if (en) begin
         q_s <= n_s;
         q_c <= n_c;
      end
   end

endmodule

// File: rtl/cs_merge.sv
module cs_merge #(
   parameter int OW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [OW-1:0] s,
   input  logic [OW-1:0] c,
   output logic [OW-1:0] y,
   output logic          y_valid
);

   // The only carry-propagating adder of the filter
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         y       <= '0;
         y_valid <= 1'b0;
      end else begin
         y_valid <= en;
         if (en) begin
            y <= s + c;
         end
      end
   end

endmodule

// File: rtl/cs_tfir.sv
module cs_tfir
   import cs_tfir_pkg::*;
#(
   parameter int                  IW     = 8,
   parameter int                  CW     = 8,
   parameter int                  NTAPS  = 4,
   parameter logic [NTAPS*CW-1:0] COEF   = {8'd1, 8'd79, 8'd55, 8'd41},
   parameter int                  OW     = 16,
   parameter recode_e             RECODE = RECODE_CSD
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic signed [IW-1:0] in_sample,
   output logic                 out_valid,
   output logic signed [OW-1:0] out_sample
);

   function automatic int coef_total();
      int t;
      t = 0;
      for (int k = 0; k < NTAPS; k++) begin
         t = t + int'(COEF[k*CW +: CW]);
      end
      return t;
   endfunction

   localparam int COEF_SUM = coef_total();
   localparam int OW_MIN   = IW + $clog2((COEF_SUM > 0) ? COEF_SUM : 1);

   if (IW < 2) begin : g_bad_iw
      $error("cs_tfir: IW must be at least 2");
   end
   if (NTAPS < 2) begin : g_bad_taps
      $error("cs_tfir: NTAPS must be at least 2");
   end
   if (CW < 1 || CW > 31) begin : g_bad_cw
      $error("cs_tfir: CW must be in 1..31");
   end
   if (OW < OW_MIN) begin : g_bad_ow
      $error("cs_tfir: OW too narrow for full-precision output");
   end

   logic [NTAPS-1:0][OW-1:0] prod_s, prod_c;
   logic [NTAPS-1:0][OW-1:0] reg_s,  reg_c;
   logic                     stage_v;
   logic [OW-1:0]            merged;

   for (genvar k = 0; k < NTAPS; k++) begin : g_tap
      cs_const_mult #(
         .IW       (IW),
         .OW       (OW),
         .CW       (CW),
         .COEF_VAL (COEF[k*CW +: CW]),
         .RECODE   (RECODE)
      ) u_mult (
         .x   (in_sample),
         .p_s (prod_s[k]),
         .p_c (prod_c[k])
      );

      if (k == NTAPS - 1) begin : g_end
         cs_tap #(.OW(OW)) u_tap (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (in_valid),
            .p_s   (prod_s[k]),
            .p_c   (prod_c[k]),
            .z_s   ('0),
            .z_c   ('0),
            .q_s   (reg_s[k]),
            .q_c   (reg_c[k])
         );
      end else begin : g_mid
         cs_tap #(.OW(OW)) u_tap (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (in_valid),
            .p_s   (prod_s[k]),
            .p_c   (prod_c[k]),
            .z_s   (reg_s[k+1]),
            .z_c   (reg_c[k+1]),
            .q_s   (reg_s[k]),
            .q_c   (reg_c[k])
         );
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_v <= 1'b0;
      end else begin
         stage_v <= in_valid;
      end
   end

   cs_merge #(.OW(OW)) u_merge (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (stage_v),
      .s       (reg_s[0]),
      .c       (reg_c[0]),
      .y       (merged),
      .y_valid (out_valid)
   );

   assign out_sample = merged;

endmodule

// File: rtl/cs_tfir_chk.sv
module cs_tfir_chk #(
   parameter int                  IW    = 8,
   parameter int                  CW    = 8,
   parameter int                  NTAPS = 4,
   parameter logic [NTAPS*CW-1:0] COEF  = '0,
   parameter int                  OW    = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic signed [IW-1:0] in_sample,
   input logic                 out_valid,
   input logic signed [OW-1:0] out_sample
);

   logic [NTAPS-2:0][IW-1:0] hist;
   logic                     v1, v2;
   logic signed [OW-1:0]     e1, e2;

   function automatic logic signed [OW-1:0] term(input logic [IW-1:0] x, input int k);
      logic signed [OW-1:0] xv, cv;
      xv = OW'($signed(x));
      cv = OW'({1'b0, COEF[k*CW +: CW]});
      return xv * cv;
   endfunction

   function automatic logic signed [OW-1:0] conv_now();
      logic signed [OW-1:0] acc;
      acc = term(in_sample, 0);
      for (int k = 1; k < NTAPS; k++) begin
         acc = acc + term(hist[k-1], k);
      end
      return acc;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist <= '0;
         v1   <= 1'b0;
         v2   <= 1'b0;
         e1   <= '0;
         e2   <= '0;
      end else begin
         v1 <= in_valid;
         v2 <= v1;
         if (in_valid) begin
            e1      <= conv_now();
            hist[0] <= in_sample;
            for (int k = 1; k < NTAPS - 1; k++) begin
               hist[k] <= hist[k-1];
            end
         end
         if (v1) begin
            e2 <= e1;
         end
      end
   end

   // R1: outputs are cleared by reset
   p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && out_sample == '0));

   // R2: each result equals the convolution of the accepted samples
   p_conv_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_sample == e2));

   // R3: valid follows an accepted sample after two register stages
   p_valid_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == v2);

   // R5: output holds while not valid
   p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_sample));

endmodule

bind cs_tfir cs_tfir_chk #(
   .IW    (IW),
   .CW    (CW),
   .NTAPS (NTAPS),
   .COEF  (COEF),
   .OW    (OW)
) u_chk (.*);

// File: tb/cs_tfir_tb.sv
module cs_tfir_tb;

   localparam int IW = 8;
   localparam int OW = 16;
   localparam int H [4] = '{41, 55, 79, 1};

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 in_valid = 1'b0;
   logic signed [IW-1:0] in_sample = '0;
   logic                 out_valid;
   logic signed [OW-1:0] out_sample;

   always #2.5 clk = ~clk;

   cs_tfir u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_sample  (in_sample),
      .out_valid  (out_valid),
      .out_sample (out_sample)
   );

   int errs = 0;
   int checks = 0;
   bit done = 1'b0;
   int hm [4];
   bit e1v = 1'b0, e2v = 1'b0;
   int e1y = 0, e2y = 0;
   int lo = 0;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int push(input int x);
      int y;
      for (int k = 3; k > 0; k--) hm[k] = hm[k-1];
      hm[0] = x;
      y = 0;
      for (int k = 0; k < 4; k++) y += H[k] * hm[k];
      return y;
   endfunction

   // One clock: check this cycle's outputs, then drive the next input
   task automatic cycle(input bit v, input int x, input string req);
      @(negedge clk);
      chk("R3 out_valid timing", int'(out_valid), int'(e2v));
      if (e2v) begin
         chk(req, int'(out_sample), e2y);
         lo = e2y;
      end else begin
         chk("R5 hold while not valid", int'(out_sample), lo);
      end
      e2v = e1v;
      e2y = e1y;
      in_valid  = v;
      in_sample = IW'(x);
      e1v = v;
      if (v) e1y = push(x);
   endtask

   task automatic do_reset(input string req);
      @(negedge clk);
      rst_n = 1'b0;
      in_valid = 1'b0;
      in_sample = '0;
      for (int k = 0; k < 4; k++) hm[k] = 0;
      e1v = 1'b0; e2v = 1'b0; lo = 0;
      repeat (2) begin
         @(negedge clk);
         chk({req, " out_valid in reset"}, int'(out_valid), 0);
         chk({req, " out_sample in reset"}, int'(out_sample), 0);
      end
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errs++;
         checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20050614));
      for (int k = 0; k < 4; k++) hm[k] = 0;

      // R1: reset state
      do_reset("R1");

      // R2: positive impulse, expect 41 55 79 1 0
      cycle(1'b1, 1, "R2 impulse +1");
      for (int i = 0; i < 6; i++) cycle(1'b1, 0, "R2 impulse +1 tail");

      // R2: negative impulse at the most negative code
      cycle(1'b1, -128, "R2 impulse -128");
      for (int i = 0; i < 5; i++) cycle(1'b1, 0, "R2 impulse -128 tail");

      // R4: impulse spread out by idle cycles
      cycle(1'b1, -5, "R4 gap impulse");
      cycle(1'b0, 77, "R4 gap idle");
      cycle(1'b0, -9, "R4 gap idle");
      for (int i = 0; i < 4; i++) begin
         cycle(1'b1, 0, "R4 gap tail");
         cycle(1'b0, 100, "R4 gap idle");
      end

      // R6: full-scale runs
      for (int i = 0; i < 6; i++) cycle(1'b1, 127, "R6 full scale +127");
      for (int i = 0; i < 6; i++) cycle(1'b1, -128, "R6 full scale -128");
      for (int i = 0; i < 5; i++) cycle(1'b1, 127, "R6 sign swing");
      for (int i = 0; i < 3; i++) cycle(1'b0, 0, "R6 idle");

      // R7: back-to-back random samples
      for (int i = 0; i < 40; i++)
         cycle(1'b1, int'($urandom_range(255)) - 128, "R7 back-to-back");

      // R2 and R4: random samples with random idle gaps
      for (int i = 0; i < 400; i++)
         cycle($urandom_range(3) != 0, int'($urandom_range(255)) - 128, "R2 random gapped");

      // R1: reset in the middle of a stream clears history
      cycle(1'b1, 90, "R1 pre-reset");
      cycle(1'b1, -70, "R1 pre-reset");
      cycle(1'b1, 33, "R1 pre-reset");
      do_reset("R1 mid-stream");
      cycle(1'b1, 2, "R1 post-reset impulse");
      for (int i = 0; i < 6; i++) cycle(1'b1, 0, "R1 post-reset tail");
      for (int i = 0; i < 4; i++) cycle(1'b0, 0, "R5 final idle");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule